// File: doc/BRIEF.md
# Combined-Event Performance Counter Bank

This block holds a bank of 64-bit hardware event counters, numbered 3 to 31, and a 64-bit event selector for each of them. Every cycle each counter picks four of the per-event count inputs, merges them pairwise through a two-level tree of programmable operators, and adds the merged value to its count. Counting can be stopped for one counter through a global inhibit register, or for the privilege mode the hart is currently in through inhibit bits held in the selector.

When a counter wraps past its top value, a sticky overflow flag in its selector is set and a local overflow interrupt request (cause number 12 in the interrupt controller) is pulsed. While the flag is already set, further wraps raise no new request. A read-only overflow vector gathers every counter's flag. Software reaches the counters, the selectors and the inhibit register through a simple write strobe and a combinational read index.

Top module: `pmu_evt_bank`

## Requirements
- R1: Selector layout: four event fields of 10 bits at 9:0, 19:10, 29:20 and 39:30, whose low 8 bits are writable and whose top 2 bits are fixed to the counter's region (00 for counters 3–10, 01 for 11–18, 10 for 19–26, 11 for 27–31); opcodes at 44:40 (first pair), 49:45 (second pair) and 54:50 (final); bits 57:55 read 0. After reset every selector holds only its region bits (for example 64'h00000040_10040100 for counters 11–18) and every counter holds 0.
- R2: An event field whose low 8 bits equal L selects the 4-bit count input at bit position (region*16+L)*4 of `evt_cnt`; L equal to 0 or L of 16 or more contributes 0.
- R3: The first pair (fields 0 and 1) and the second pair (fields 2 and 3) are each merged by their own opcode, and the two results are merged by the final opcode; opcode 0 is OR, 1 is AND, 2 is XOR, 4 is ADD, and any other value acts as OR. Values are zero-extended to 6 bits first.
- R4: On each clock edge a counting counter adds the final merged value; the new count is visible on `rd_count` after that edge, and the count wraps modulo 2^64.
- R5: The inhibit register (written with `wr_kind`=2 from `wr_data[31:0]`, reset 0) stops counter n while bit n is 1; bit 2 always reads 0.
- R6: Privilege mode is encoded M=0, S=1, U=2, VS=3, VU=4; selector bit 62 stops counting in M, 61 in S, 60 in U, 59 in VS and 58 in VU.
- R7: A wrap while the overflow flag (selector bit 63) is 0 sets the flag and drives `ovf_irq` high for exactly the cycle after that edge; a wrap while the flag is 1 leaves it set and raises no request.
- R8: `ovf_vec` bit n equals counter n's overflow flag; bits 2:0 read 0.
- R9: A counter write (`wr_kind`=0) in the same cycle as an increment wins: the counter takes `wr_data` and the increment is dropped. A selector write (`wr_kind`=1) replaces the whole selector, flag included.
- R10: Reads at indices 0–2 return 0 on `rd_count` and `rd_sel`, and counter or selector writes to those indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 3 | Current privilege mode of the hart |
| evt_cnt | input | 4*REG_EVTS*EVT_W | Per-event count inputs for this cycle |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 counter, 1 selector, 2 inhibit register |
| wr_idx | input | 5 | Counter number for counter and selector writes |
| wr_data | input | 64 | Write data |
| rd_idx | input | 5 | Counter number to read |
| rd_count | output | 64 | Count of the addressed counter |
| rd_sel | output | 64 | Selector of the addressed counter |
| inhibit_o | output | 32 | Inhibit register contents |
| ovf_vec | output | 32 | Overflow flags of all counters |
| ovf_irq | output | 1 | Overflow interrupt request pulse |

## Verification
The hardest situation to reach is a wrap of a 64-bit counter, and above all a second wrap while the flag is still set, since no run could count that far from zero. The bench writes a counter a few dozen below its top value, holds every selected event at its maximum with an all-ADD tree so the next edge wraps, then repeats the write to force a second wrap with the flag already set. A reference model updated on every edge is compared against all outputs each cycle while events are random, modes rotate and writes collide with increments.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int SEL_W        = 64;
    localparam int CNT_W        = 64;
    localparam int FLD_W        = 10;
    localparam int LOW_W        = 8;
    localparam int OP_W         = 5;
    localparam int N_FIELDS     = 4;
    localparam int N_OPS        = 3;
    localparam int N_SLOTS      = 32;
    localparam int RSVD_INH_BIT = 2;
    localparam int OVF_CAUSE    = 12;

    typedef enum logic [OP_W-1:0] {
        OP_OR  = 5'd0,
        OP_AND = 5'd1,
        OP_XOR = 5'd2,
        OP_ADD = 5'd4
    } comb_op_e;

    typedef enum logic [2:0] {
        PRIV_M  = 3'd0,
        PRIV_S  = 3'd1,
        PRIV_U  = 3'd2,
        PRIV_VS = 3'd3,
        PRIV_VU = 3'd4
    } priv_e;

    typedef enum logic [1:0] {
        WR_COUNT   = 2'd0,
        WR_SELECT  = 2'd1,
        WR_INHIBIT = 2'd2
    } wr_kind_e;

    typedef struct packed {
        logic                            of;
        logic [4:0]                      inh;   // [4]=M [3]=S [2]=U [1]=VS [0]=VU
        logic [N_OPS-1:0][OP_W-1:0]      op;
        logic [N_FIELDS-1:0][LOW_W-1:0]  evt;
    } sel_t;

    function automatic int mode_inh_idx(logic [2:0] mode);
        case (mode)
            PRIV_S:  return 3;
            PRIV_U:  return 2;
            PRIV_VS: return 1;
            PRIV_VU: return 0;
            default: return 4;
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] pack_sel(sel_t s, logic [1:0] region);
        logic [SEL_W-1:0] w;
        w        = '0;
        w[63]    = s.of;
        w[62:58] = s.inh;
        for (int k = 0; k < N_OPS; k++) w[40 + k*OP_W +: OP_W] = s.op[k];
        for (int k = 0; k < N_FIELDS; k++) begin
            w[k*FLD_W +: LOW_W]         = s.evt[k];
            w[k*FLD_W + LOW_W +: 2]     = region;
        end
        return w;
    endfunction

    function automatic sel_t unpack_sel(logic [SEL_W-1:0] w);
        sel_t s;
        s.of  = w[63];
        s.inh = w[62:58];
        for (int k = 0; k < N_OPS; k++) s.op[k] = w[40 + k*OP_W +: OP_W];
        for (int k = 0; k < N_FIELDS; k++) s.evt[k] = w[k*FLD_W +: LOW_W];
        return s;
    endfunction

endpackage

// File: rtl/pmu_evt_pick.sv
module pmu_evt_pick
    import pmu_pkg::*;
#(
    parameter int EVT_W    = 4,
    parameter int REG_EVTS = 16,
    parameter int REGION   = 0
) (
    input  logic [4*REG_EVTS*EVT_W-1:0]        evt_cnt,
    input  logic [N_FIELDS-1:0][LOW_W-1:0]     idx_lo,
    output logic [N_FIELDS-1:0][EVT_W-1:0]     picked
);
    localparam int BASE = REGION * REG_EVTS;

    for (genvar k = 0; k < N_FIELDS; k++) begin : g_lane
        logic in_range;
        int   src;
        always_comb begin
            in_range  = (idx_lo[k] != '0) && (int'(idx_lo[k]) < REG_EVTS);
            src       = in_range ? BASE + int'(idx_lo[k]) : BASE;
            picked[k] = in_range ? evt_cnt[src*EVT_W +: EVT_W] : '0;
        end
    end
endmodule

// File: rtl/pmu_combine.sv
module pmu_combine
    import pmu_pkg::*;
#(
    parameter int EVT_W = 4,
    parameter int RES_W = EVT_W + 2
) (
    input  logic [N_FIELDS-1:0][EVT_W-1:0] ev,
    input  logic [N_OPS-1:0][OP_W-1:0]     op,
    output logic [RES_W-1:0]               res
);
    function automatic logic [RES_W-1:0] apply(logic [OP_W-1:0] code,
                                               logic [RES_W-1:0] a,
                                               logic [RES_W-1:0] b);
        case (code)
            OP_AND:  return a & b;
            OP_XOR:  return a ^ b;
            OP_ADD:  return a + b;
            default: return a | b;
        endcase
    endfunction

    logic [N_FIELDS-1:0][RES_W-1:0] ext;
    logic [RES_W-1:0]               pair_lo, pair_hi;

    always_comb begin
        for (int k = 0; k < N_FIELDS; k++) ext[k] = RES_W'(ev[k]);
        pair_lo = apply(op[0], ext[0], ext[1]);
        pair_hi = apply(op[1], ext[2], ext[3]);
        res     = apply(op[2], pair_lo, pair_hi);
    end
endmodule

// File: rtl/pmu_ctr_slot.sv
module pmu_ctr_slot
    import pmu_pkg::*;
#(
    parameter int CTR_ID    = 3,
    parameter int FIRST_CTR = 3,
    parameter int EVT_W     = 4,
    parameter int REG_EVTS  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [2:0]                    priv,
    input  logic                          glob_inh,
    input  logic [4*REG_EVTS*EVT_W-1:0]   evt_cnt,
    input  logic                          cnt_wr,
    input  logic                          sel_wr,
    input  logic [SEL_W-1:0]              wr_data,
    output logic [CNT_W-1:0]              count,
    output logic [SEL_W-1:0]              sel_word,
    output logic                          irq_req
);
    localparam int RAW_REGION = (CTR_ID - FIRST_CTR) / 8;
    localparam int REGION     = (RAW_REGION > 3) ? 3 : RAW_REGION;
    localparam int RES_W      = EVT_W + 2;

    sel_t                              sel_q;
    logic [N_FIELDS-1:0][EVT_W-1:0]    picked;
    logic [RES_W-1:0]                  res;
    logic [CNT_W:0]                    sum;
    logic                              count_en, wrap_hit;

    pmu_evt_pick #(.EVT_W(EVT_W), .REG_EVTS(REG_EVTS), .REGION(REGION)) u_pick (
        .evt_cnt (evt_cnt),
        .idx_lo  (sel_q.evt),
        .picked  (picked)
    );

    pmu_combine #(.EVT_W(EVT_W), .RES_W(RES_W)) u_comb (
        .ev  (picked),
        .op  (sel_q.op),
        .res (res)
    );

    always_comb begin
        count_en = !glob_inh && !sel_q.inh[mode_inh_idx(priv)];
        sum      = {1'b0, count} + (CNT_W+1)'(res);
        wrap_hit = count_en && !cnt_wr && sum[CNT_W];
        irq_req  = wrap_hit && !sel_q.of;
        sel_word = pack_sel(sel_q, 2'(REGION));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            sel_q <= '0;
        end else begin
            if (cnt_wr)        count <= wr_data;
            else if (count_en) count <= sum[CNT_W-1:0];
            if (sel_wr)        sel_q <= unpack_sel(wr_data);
            else if (wrap_hit) sel_q.of <= 1'b1;
        end
    end

    // R5 / R6: a gated counter without a write keeps its value
    assert_gated_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !cnt_wr) |=> $stable(count));

    // R7: the overflow flag stays set until software rewrites the selector
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_q.of && !sel_wr) |=> sel_q.of);

    // R7: a wrap leaves the flag set
    assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap_hit && !sel_wr) |=> sel_q.of);

    // R9: a counter write beats the increment
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count == $past(wr_data)));
endmodule

// File: rtl/pmu_evt_bank.sv
module pmu_evt_bank
    import pmu_pkg::*;
#(
    parameter int EVT_W     = 4,
    parameter int REG_EVTS  = 16,
    parameter int FIRST_CTR = 3,
    parameter int LAST_CTR  = 31
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [2:0]                    priv_mode,
    input  logic [4*REG_EVTS*EVT_W-1:0]   evt_cnt,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_kind,
    input  logic [4:0]                    wr_idx,
    input  logic [63:0]                   wr_data,
    input  logic [4:0]                    rd_idx,
    output logic [63:0]                   rd_count,
    output logic [63:0]                   rd_sel,
    output logic [31:0]                   inhibit_o,
    output logic [31:0]                   ovf_vec,
    output logic                          ovf_irq
);
    logic [CNT_W-1:0]   cnt_arr [N_SLOTS];
    logic [SEL_W-1:0]   sel_arr [N_SLOTS];
    logic [N_SLOTS-1:0] irq_vec;
    logic [N_SLOTS-1:0] inh_q;
    logic               ovf_irq_q;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        if (g >= FIRST_CTR && g <= LAST_CTR) begin : g_on
            logic hit_cnt, hit_sel;
            assign hit_cnt = wr_en && (wr_kind == WR_COUNT)  && (int'(wr_idx) == g);
            assign hit_sel = wr_en && (wr_kind == WR_SELECT) && (int'(wr_idx) == g);
            pmu_ctr_slot #(
                .CTR_ID(g), .FIRST_CTR(FIRST_CTR), .EVT_W(EVT_W), .REG_EVTS(REG_EVTS)
            ) u_ctr (
                .clk      (clk),
                .rst      (rst),
                .priv     (priv_mode),
                .glob_inh (inh_q[g]),
                .evt_cnt  (evt_cnt),
                .cnt_wr   (hit_cnt),
                .sel_wr   (hit_sel),
                .wr_data  (wr_data),
                .count    (cnt_arr[g]),
                .sel_word (sel_arr[g]),
                .irq_req  (irq_vec[g])
            );
        end else begin : g_off
            assign cnt_arr[g] = '0;
            assign sel_arr[g] = '0;
            assign irq_vec[g] = 1'b0;
        end
        assign ovf_vec[g] = sel_arr[g][63];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_q     <= '0;
            ovf_irq_q <= 1'b0;
        end else begin
            if (wr_en && wr_kind == WR_INHIBIT)
                inh_q <= wr_data[N_SLOTS-1:0] & ~(N_SLOTS'(1) << RSVD_INH_BIT);
            ovf_irq_q <= |irq_vec;
        end
    end

    assign rd_count  = cnt_arr[rd_idx];
    assign rd_sel    = sel_arr[rd_idx];
    assign inhibit_o = inh_q;
    assign ovf_irq   = ovf_irq_q;

    // R7: a request pulse is never two cycles long unless a new wrap arrived
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq && !(|irq_vec)) |=> !ovf_irq);
endmodule

// File: tb/pmu_evt_bank_tb_top.sv
module pmu_evt_bank_tb_top;
    localparam int EVT_W = 4;
    localparam int REG_EVTS = 16;
    localparam int EW = 4*REG_EVTS*EVT_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    priv_mode = 3'd0;
    logic [EW-1:0] evt_cnt = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'd0;
    logic [4:0]    wr_idx = 5'd0;
    logic [63:0]   wr_data = '0;
    logic [4:0]    rd_idx = 5'd0;
    logic [63:0]   rd_count, rd_sel;
    logic [31:0]   inhibit_o, ovf_vec;
    logic          ovf_irq;

    int checks = 0;
    int errors = 0;

    pmu_evt_bank dut_i (
        .clk(clk), .rst(rst), .priv_mode(priv_mode), .evt_cnt(evt_cnt),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_count(rd_count), .rd_sel(rd_sel),
        .inhibit_o(inhibit_o), .ovf_vec(ovf_vec), .ovf_irq(ovf_irq)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    logic [63:0] m_cnt [32];
    logic [63:0] m_sel [32];
    logic [31:0] m_inh;
    logic        m_irq;

    function automatic logic [63:0] sel_mask(int n, logic [63:0] w);
        logic [63:0] o;
        int r;
        r = (n - 3) / 8;
        o = w & (64'hFC00_0000_0000_0000 | 64'h007F_FF00_0000_0000);
        for (int k = 0; k < 4; k++) begin
            o[k*10 +: 8]     = w[k*10 +: 8];
            o[k*10 + 8 +: 2] = 2'(r);
        end
        return o;
    endfunction

    function automatic int opf(int op, int a, int b);
        case (op)
            1: return a & b;
            2: return a ^ b;
            4: return a + b;
            default: return a | b;
        endcase
    endfunction

    function automatic int ev_of(int n, int k);
        int r, lo;
        r  = (n - 3) / 8;
        lo = int'(m_sel[n][k*10 +: 8]);
        if (lo == 0 || lo >= REG_EVTS) return 0;
        return int'(evt_cnt[(r*REG_EVTS + lo)*EVT_W +: EVT_W]);
    endfunction

    function automatic int res_of(int n);
        int a, b;
        a = opf(int'(m_sel[n][44:40]), ev_of(n, 0), ev_of(n, 1));
        b = opf(int'(m_sel[n][49:45]), ev_of(n, 2), ev_of(n, 3));
        return opf(int'(m_sel[n][54:50]), a, b);
    endfunction

    function automatic int mode_bit(logic [2:0] m);
        case (m)
            3'd1: return 3;
            3'd2: return 2;
            3'd3: return 1;
            3'd4: return 0;
            default: return 4;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < 32; n++) begin
                m_cnt[n] = '0;
                m_sel[n] = (n >= 3) ? sel_mask(n, 64'd0) : 64'd0;
            end
            m_inh = '0;
            m_irq = 1'b0;
        end else begin
            logic irq;
            irq = 1'b0;
            for (int n = 3; n < 32; n++) begin
                logic        gate, cw, sw, wrapped;
                logic [64:0] s;
                gate = m_inh[n] || m_sel[n][58 + mode_bit(priv_mode)];
                s    = {1'b0, m_cnt[n]} + 65'(res_of(n));
                cw   = wr_en && wr_kind == 2'd0 && int'(wr_idx) == n;
                sw   = wr_en && wr_kind == 2'd1 && int'(wr_idx) == n;
                wrapped = !gate && !cw && s[64];
                if (wrapped && !m_sel[n][63]) irq = 1'b1;
                if (cw) m_cnt[n] = wr_data;
                else if (!gate) m_cnt[n] = s[63:0];
                if (sw) m_sel[n] = sel_mask(n, wr_data);
                else if (wrapped) m_sel[n][63] = 1'b1;
            end
            if (wr_en && wr_kind == 2'd2) m_inh = wr_data[31:0] & ~32'h4;
            m_irq = irq;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int i;
        logic [31:0] ov;
        i = int'(rd_idx);
        ov = '0;
        for (int n = 3; n < 32; n++) ov[n] = m_sel[n][63];
        chk({tag, " count R4"}, rd_count, (i >= 3) ? m_cnt[i] : 64'd0);
        chk({tag, " sel R1"}, rd_sel, (i >= 3) ? m_sel[i] : 64'd0);
        chk({tag, " ovf_vec R8"}, {32'd0, ovf_vec}, {32'd0, ov});
        chk({tag, " inhibit R5"}, {32'd0, inhibit_o}, {32'd0, m_inh});
        chk({tag, " irq R7"}, {63'd0, ovf_irq}, {63'd0, m_irq});
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all(tag);
        rd_idx = (rd_idx == 5'd31) ? 5'd0 : rd_idx + 5'd1;
    endtask

    task automatic wr(logic [1:0] kind, int idx, logic [63:0] data, string tag);
        wr_en = 1'b1; wr_kind = kind; wr_idx = 5'(idx); wr_data = data;
        tick(tag);
    endtask

    task automatic peek(int idx);
        rd_idx = 5'(idx);
        #1;
    endtask

    task automatic rand_evt();
        for (int i = 0; i < 4*REG_EVTS; i++) evt_cnt[i*EVT_W +: EVT_W] = 4'($urandom_range(0, 15));
    endtask

    function automatic logic [63:0] mk_sel(int e0, int e1, int e2, int e3, int o0, int o1, int o2);
        return 64'(e0) | (64'(e1) << 10) | (64'(e2) << 20) | (64'(e3) << 30)
             | (64'(o0) << 40) | (64'(o1) << 45) | (64'(o2) << 50);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [63:0] held;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare_all("R1 reset");
        peek(11); chk("R1 reset pattern region1", rd_sel, 64'h0000_0040_1004_0100);
        peek(27); chk("R1 reset pattern region3", rd_sel, 64'h0000_00C0_300C_0300);
        peek(3);  chk("R1 reset pattern region0", rd_sel, 64'h0);
        chk("R4 reset count", rd_count, 64'h0);

        // selectors: R2 out-of-range field, R3 operators incl. unknown code
        wr(2'd1, 3,  mk_sel(1, 2, 3, 20, 4, 2, 4) | 64'h0380_0000_0000_0300, "R2 write");
        peek(3); chk("R1 top bits and 57:55 masked", rd_sel, mk_sel(1, 2, 3, 20, 4, 2, 4));
        wr(2'd1, 4,  mk_sel(5, 6, 7, 8, 1, 0, 2), "R3 write");
        wr(2'd1, 12, mk_sel(5, 0, 7, 9, 7, 1, 4), "R3 write");
        wr(2'd1, 20, mk_sel(2, 3, 4, 5, 4, 4, 4) | (64'd1 << 61), "R6 write");
        wr(2'd1, 28, mk_sel(1, 2, 3, 4, 4, 4, 4), "R3 write");
        for (int c = 0; c < 64; c++) begin
            rand_evt();
            tick("R3 R2 random events");
        end

        // R6: rotate privilege modes
        for (int c = 0; c < 50; c++) begin
            rand_evt();
            priv_mode = 3'(c % 5);
            tick("R6 modes");
        end
        priv_mode = 3'd1;
        peek(20); held = rd_count;
        for (int c = 0; c < 4; c++) begin rand_evt(); tick("R6 S inhibited"); end
        peek(20); chk("R6 counter 20 frozen in S", rd_count, held);
        priv_mode = 3'd0;

        // R5: global inhibit incl. reserved bit
        wr(2'd2, 0, 64'h0000_0000_0000_0014, "R5 inhibit write");
        chk("R5 reserved bit reads 0", {32'd0, inhibit_o}, 64'h10);
        peek(4); held = rd_count;
        for (int c = 0; c < 6; c++) begin rand_evt(); tick("R5 inhibited"); end
        peek(4); chk("R5 counter 4 frozen", rd_count, held);
        wr(2'd2, 0, 64'h0, "R5 inhibit clear");

        // R7/R8: overflow
        evt_cnt = '1;
        wr(2'd0, 28, 64'hFFFF_FFFF_FFFF_FFF0, "R9 preload");
        tick("R7 first wrap");
        chk("R7 irq on first wrap", {63'd0, ovf_irq}, 64'd1);
        chk("R8 flag in vector", {63'd0, ovf_vec[28]}, 64'd1);
        peek(28); chk("R4 wrapped count", rd_count, 64'h2C);
        tick("R7 after wrap");
        chk("R7 irq one cycle", {63'd0, ovf_irq}, 64'd0);
        wr(2'd0, 28, 64'hFFFF_FFFF_FFFF_FFF0, "R9 preload again");
        tick("R7 second wrap");
        chk("R7 no irq with flag set", {63'd0, ovf_irq}, 64'd0);
        chk("R7 flag still set", {63'd0, ovf_vec[28]}, 64'd1);
        wr(2'd1, 28, mk_sel(1, 2, 3, 4, 4, 4, 4), "R9 selector rewrite clears flag");
        chk("R9 flag cleared", {63'd0, ovf_vec[28]}, 64'd0);

        // R9: write beats increment
        wr(2'd0, 3, 64'd100, "R9 write");
        peek(3); chk("R9 write wins", rd_count, 64'd100);
        tick("R9 resume counting");

        // R10: writes below counter 3 ignored
        wr(2'd0, 1, 64'h55, "R10 write");
        wr(2'd1, 2, 64'hFFFF_FFFF_FFFF_FFFF, "R10 write");
        peek(1); chk("R10 count idx1", rd_count, 64'd0);
        peek(2); chk("R10 sel idx2", rd_sel, 64'd0);
        chk("R8 low bits zero", {61'd0, ovf_vec[2:0]}, 64'd0);

        for (int c = 0; c < 40; c++) begin
            rand_evt();
            priv_mode = 3'($urandom_range(0, 4));
            if (c % 7 == 3) wr(2'd0, 3 + (c % 29), 64'hFFFF_FFFF_FFFF_FFE0, "R9 R7 collide");
            else tick("R4 mixed");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule